// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter with Break Field

This block turns characters into an asynchronous serial bit stream on a single output line. A character is written with a one-cycle strobe into a one-entry holding register. The block then sends it as a frame on the baud grid set by an external one-cycle tick: one start bit, 7 or 8 data bits, an optional parity bit and one or two stop bits. Each bit lasts exactly one tick interval. Bit order, parity mode, character length and stop count are configuration inputs. They are latched when a frame is loaded, so later changes do not disturb a frame already on the line.

A separate write strobe queues a synchronization break in place of a character. A break holds the line at its active level (low) for 13 to 20 bit times, then sends one idle bit time before anything else. An inversion input complements the line level, including the idle level. A busy flag covers both the frame on the line and the holding register. A one-cycle completion pulse marks the moment the last data bit of a character has been sent.

Top module: `lin_uart_tx`

## Requirements
- R1: After reset, the line is idle high (with inversion off), `busy` is 0 and `tx_done` is 0.
- R2: A character frame begins on the first `baud_tick` after the write with one low start bit. Data bits follow, one per tick interval, least significant bit first when `cfg_msb_first` is 0.
- R3: With `cfg_len8`=1 the frame carries 8 data bits. With `cfg_len8`=0 it carries 7 data bits, taken from `wr_data[6:0]`, and bit 7 is never sent.
- R4: `cfg_parity` selects the bit sent after the data: 0 = no parity bit, 1 = even, 2 = odd, 3 = a bit forced to 0. Even and odd are computed over the data bits actually sent.
- R5: One stop bit (high) is sent when `cfg_stop2`=0, and two stop bits when it is 1.
- R6: With `cfg_msb_first`=1 the sent data bits run from the highest sent bit (bit 7, or bit 6 for 7-bit characters) down to bit 0.
- R7: With `cfg_invert`=1 every line level is complemented, including the idle level.
- R8: A `wr_break` write sends 13 + `cfg_brk_sel` low bit times (`cfg_brk_sel` is 3 bits), then exactly one high bit time before the line is free for the next frame.
- R9: `tx_done` is high for exactly one clock per character. It rises on the tick that ends the last data bit. A break produces no pulse.
- R10: A write accepted while a frame is on the line is held. It starts on the same tick that ends the final stop bit, or the final break idle bit, with no gap. A write made while the holding register is already full is ignored. If `wr_break` and `wr_en` arrive together, the break is taken.
- R11: `busy` is 1 from the cycle after an accepted write until the tick that ends the last frame, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Queue a character |
| wr_data | input | 8 | Character to queue |
| wr_break | input | 1 | Queue a break field instead of a character |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 forced zero |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_msb_first | input | 1 | 1 = most significant data bit first |
| cfg_invert | input | 1 | Complement the output level |
| cfg_brk_sel | input | 3 | Break length is 13 plus this value, in bit times |
| tx_line | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress or character held |
| tx_done | output | 1 | One-cycle pulse after the last data bit of a character |

## Verification
The bench sends one frame for every combination of length, parity mode, stop count, bit order and inversion, each with different data. It compares the sampled line bit by bit against a frame assembled arithmetically, so any swapped order, miscounted parity or missing stop bit shows up as a mismatch at a known bit position. Breaks are swept over all eight lengths with both line polarities, which separates an off-by-one in the low count from a missing idle bit. Two queued sequences, a character behind a character and a character behind a break, check that no gap is inserted and that a third write made while the holding register is full leaves no trace on the line.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

    localparam int CHAR_W     = 8;
    localparam int CHAR_IDX_W = $clog2(CHAR_W);
    localparam int BRK_SEL_W  = 3;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_ZERO = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_BRK_GAP
    } tx_state_e;

    typedef struct packed {
        logic              is_brk;
        logic [CHAR_W-1:0] data;
    } hold_entry_t;

    typedef struct packed {
        logic                 len8;
        par_mode_e            par;
        logic                 stop2;
        logic                 msb;
        logic [BRK_SEL_W-1:0] brk_sel;
    } frame_cfg_t;

    // data bit sent in slot idx for the given length and order
    function automatic logic pick_bit(input logic [CHAR_W-1:0] d, input int idx,
                                      input logic len8, input logic msb);
        int n;
        int pos;
        n   = len8 ? CHAR_W : CHAR_W - 1;
        pos = msb ? (n - 1 - idx) : idx;
        return d[pos[CHAR_IDX_W-1:0]];
    endfunction

    // parity over the bits that are actually sent
    function automatic logic calc_parity(input logic [CHAR_W-1:0] d, input logic len8,
                                         input par_mode_e mode);
        logic [CHAR_W-1:0] m;
        m = d;
        if (!len8) m[CHAR_W-1] = 1'b0;
        case (mode)
            PAR_EVEN: return ^m;
            PAR_ODD:  return ~^m;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lin_tx_hold.sv
module lin_tx_hold
    import lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push_chr,
    input  logic              push_brk,
    input  logic [CHAR_W-1:0] data_in,
    input  logic              pop,
    output logic              vld,
    output hold_entry_t       entry
);

    logic accept;

    // a write while full is dropped; a break wins over a character
    assign accept = (push_chr | push_brk) & ~vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            entry <= '0;
        end else begin
            if (accept) begin
                vld          <= 1'b1;
                entry.is_brk <= push_brk;
                entry.data   <= data_in;
            end else if (pop) begin
                vld <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lin_tx_seq.sv
module lin_tx_seq
    import lin_tx_pkg::*;
#(
    parameter int BRK_MIN = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        hold_vld,
    input  hold_entry_t hold_q,
    input  frame_cfg_t  cfg_in,
    output logic        pop,
    output logic        line_raw,
    output logic        active,
    output logic        done_pulse
);

    localparam int BRK_MAX = BRK_MIN + (1 << BRK_SEL_W) - 1;
    localparam int CNT_W   = $clog2(BRK_MAX + 1);

    tx_state_e               state;
    logic [CHAR_W-1:0]       cur_data;
    frame_cfg_t              cfg_q;
    logic [CHAR_IDX_W-1:0]   bit_idx;
    logic [CHAR_IDX_W-1:0]   last_idx;
    logic [CNT_W-1:0]        brk_cnt;
    logic [CNT_W-1:0]        brk_last;
    logic                    stop_sec;
    logic                    done_q;
    logic                    finishing;
    logic                    load;
    logic                    rel;

    assign last_idx = cfg_q.len8 ? CHAR_IDX_W'(CHAR_W - 1) : CHAR_IDX_W'(CHAR_W - 2);
    assign brk_last = CNT_W'(BRK_MIN - 1) + CNT_W'(cfg_q.brk_sel);

    // frame ends on a tick in the final stop bit or the post-break idle bit
    always_comb begin
        finishing = 1'b0;
        if (state == ST_STOP && (!cfg_q.stop2 || stop_sec)) finishing = 1'b1;
        if (state == ST_BRK_GAP) finishing = 1'b1;
    end

    assign load   = hold_vld & ((state == ST_IDLE) | finishing);
    assign rel    = finishing & ~hold_vld;
    assign pop    = tick & load;
    assign active = (state != ST_IDLE);
    assign done_pulse = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_data <= '0;
            cfg_q    <= '0;
            bit_idx  <= '0;
            brk_cnt  <= '0;
            stop_sec <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                case (state)
                    ST_START: begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                    ST_DATA: begin
                        if (bit_idx == last_idx) begin
                            done_q   <= 1'b1;
                            stop_sec <= 1'b0;
                            state    <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PAR;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        state    <= ST_STOP;
                        stop_sec <= 1'b0;
                    end
                    ST_STOP: begin
                        if (cfg_q.stop2 && !stop_sec) stop_sec <= 1'b1;
                    end
                    ST_BRK: begin
                        if (brk_cnt == brk_last) state <= ST_BRK_GAP;
                        else brk_cnt <= brk_cnt + 1'b1;
                    end
                    default: ;
                endcase
                if (load) begin
                    state    <= hold_q.is_brk ? ST_BRK : ST_START;
                    cur_data <= hold_q.data;
                    cfg_q    <= cfg_in;
                    brk_cnt  <= '0;
                end else if (rel) begin
                    state <= ST_IDLE;
                end
            end
        end
    end

    always_comb begin
        case (state)
            ST_START: line_raw = 1'b0;
            ST_DATA:  line_raw = pick_bit(cur_data, int'(bit_idx), cfg_q.len8, cfg_q.msb);
            ST_PAR:   line_raw = calc_parity(cur_data, cfg_q.len8, cfg_q.par);
            ST_BRK:   line_raw = 1'b0;
            default:  line_raw = 1'b1;
        endcase
    end

endmodule

// File: rtl/lin_tx_line_out.sv
module lin_tx_line_out (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    input  logic invert,
    output logic tx_line
);

    always_ff @(posedge clk) begin
        if (rst) tx_line <= ~invert;
        else     tx_line <= line_raw ^ invert;
    end

endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
    import lin_tx_pkg::*;
#(
    parameter int BRK_MIN = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic                 wr_en,
    input  logic [CHAR_W-1:0]    wr_data,
    input  logic                 wr_break,
    input  logic                 cfg_len8,
    input  logic [1:0]           cfg_parity,
    input  logic                 cfg_stop2,
    input  logic                 cfg_msb_first,
    input  logic                 cfg_invert,
    input  logic [BRK_SEL_W-1:0] cfg_brk_sel,
    output logic                 tx_line,
    output logic                 busy,
    output logic                 tx_done
);

    frame_cfg_t  cfg_now;
    hold_entry_t hold_q;
    logic        hold_vld;
    logic        pop;
    logic        line_raw;
    logic        active;

    always_comb begin
        cfg_now.len8    = cfg_len8;
        cfg_now.par     = par_mode_e'(cfg_parity);
        cfg_now.stop2   = cfg_stop2;
        cfg_now.msb     = cfg_msb_first;
        cfg_now.brk_sel = cfg_brk_sel;
    end

    lin_tx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .push_chr (wr_en),
        .push_brk (wr_break),
        .data_in  (wr_data),
        .pop      (pop),
        .vld      (hold_vld),
        .entry    (hold_q)
    );

    lin_tx_seq #(.BRK_MIN(BRK_MIN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .hold_vld   (hold_vld),
        .hold_q     (hold_q),
        .cfg_in     (cfg_now),
        .pop        (pop),
        .line_raw   (line_raw),
        .active     (active),
        .done_pulse (tx_done)
    );

    lin_tx_line_out u_out (
        .clk      (clk),
        .rst      (rst),
        .line_raw (line_raw),
        .invert   (cfg_invert),
        .tx_line  (tx_line)
    );

    assign busy = active | hold_vld;

endmodule

// File: rtl/lin_uart_tx_chk.sv
module lin_uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic wr_en,
    input logic wr_break,
    input logic cfg_invert,
    input logic tx_line,
    input logic busy,
    input logic tx_done
);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R9
    done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> $past(baud_tick));

    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> busy);

    // R11
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || wr_break) |=> busy);

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (tx_line == !$past(cfg_invert)));

endmodule

bind lin_uart_tx lin_uart_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .wr_break   (wr_break),
    .cfg_invert (cfg_invert),
    .tx_line    (tx_line),
    .busy       (busy),
    .tx_done    (tx_done)
);

// File: tb/lin_uart_tx_bench.sv
module lin_uart_tx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_break = 1'b0;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [2:0] cfg_brk_sel = 3'd0;
    logic       tx_line;
    logic       busy;
    logic       tx_done;

    int total = 0;
    int bad = 0;

    logic        cap [0:511];
    int          cap_n = 0;
    int          done_cnt = 0;
    int          done_at = -1;
    int          ph = 0;
    logic [63:0] exp_v;
    int          exp_n;

    lin_uart_tx u_lin_uart_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .wr_break(wr_break), .cfg_len8(cfg_len8), .cfg_parity(cfg_parity),
        .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_brk_sel(cfg_brk_sel), .tx_line(tx_line), .busy(busy), .tx_done(tx_done)
    );

    always #5 clk = ~clk;

    // tick every 4 clocks; sample the line mid-bit, un-inverted
    always @(negedge clk) begin
        if (tx_done) begin
            done_cnt = done_cnt + 1;
            done_at  = cap_n;
        end
        if (ph == 2 && cap_n < 512) begin
            cap[cap_n] = tx_line ^ cfg_invert;
            cap_n = cap_n + 1;
        end
        ph = (ph + 1) % 4;
        baud_tick = (ph == 0);
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push_bit(input logic b);
        exp_v[exp_n] = b;
        exp_n = exp_n + 1;
    endtask

    task automatic add_frame(input logic [7:0] d, input logic len8, input int par,
                             input logic stop2, input logic msb);
        int n;
        int ones;
        n = len8 ? 8 : 7;
        ones = 0;
        push_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            int p;
            p = msb ? (n - 1 - i) : i;
            push_bit(d[p]);
            ones = ones + int'(d[p]);
        end
        if (par == 1) push_bit(logic'(ones % 2));
        if (par == 2) push_bit(logic'(1 - ones % 2));
        if (par == 3) push_bit(1'b0);
        push_bit(1'b1);
        if (stop2) push_bit(1'b1);
    endtask

    task automatic add_break(input int sel);
        for (int i = 0; i < 13 + sel; i++) push_bit(1'b0);
        push_bit(1'b1);
    endtask

    task automatic clear_cap();
        repeat (2) @(posedge clk);
        cap_n = 0;
        done_cnt = 0;
        done_at = -1;
        exp_v = '0;
        exp_n = 0;
    endtask

    task automatic wait_idle(input string tag);
        int guard;
        guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, tag, busy, 0);
        repeat (12) @(posedge clk);
    endtask

    // returns index of start bit; compares stream and idle tail
    task automatic check_stream(input string tag, output int s);
        logic [63:0] act;
        logic        tail_ok;
        s = -1;
        for (int i = 0; i < cap_n; i++) begin
            if (s < 0 && cap[i] == 1'b0) s = i;
        end
        act = '0;
        if (s >= 0) begin
            for (int i = 0; i < exp_n; i++) act[i] = cap[s + i];
        end
        chk(s >= 0 && act == exp_v, tag, act, exp_v);
        tail_ok = (s >= 0) && (s + exp_n < cap_n);
        if (s >= 0) begin
            for (int i = s + exp_n; i < cap_n; i++) if (cap[i] != 1'b1) tail_ok = 1'b0;
        end
        chk(tail_ok, {tag, " idle tail"}, cap_n, s + exp_n);
    endtask

    task automatic write_chr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_brk();
        @(negedge clk);
        wr_break = 1'b1;
        @(negedge clk);
        wr_break = 1'b0;
    endtask

    task automatic wait_start();
        int guard;
        guard = 0;
        while ((tx_line ^ cfg_invert) != 1'b0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        int   k;
        int   s;
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 idle line", tx_line, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(tx_done == 1'b0, "R1 done", tx_done, 0);

        // sweep of all frame formats: R2 R3 R4 R5 R6 R7 R9 R11
        k = 0;
        for (int l = 0; l < 2; l++)
        for (int p = 0; p < 4; p++)
        for (int st = 0; st < 2; st++)
        for (int m = 0; m < 2; m++)
        for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            cfg_len8 = logic'(l);
            cfg_parity = 2'(p);
            cfg_stop2 = logic'(st);
            cfg_msb_first = logic'(m);
            cfg_invert = logic'(v);
            d = 8'(8'h5A + k * 29);
            k++;
            @(negedge clk);
            @(negedge clk);
            chk(tx_line == ~cfg_invert, "R7 idle level", tx_line, ~cfg_invert);
            clear_cap();
            add_frame(d, logic'(l), p, logic'(st), logic'(m));
            write_chr(d);
            chk(busy == 1'b1, "R11 busy after write", busy, 1);
            wait_idle("R11 busy clears");
            check_stream($sformatf("R2 R3 R4 R5 R6 frame l%0d p%0d s%0d m%0d v%0d", l, p, st, m, v), s);
            chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
            chk(done_at == s + 1 + (l ? 8 : 7), "R9 done after last data bit", done_at, s + 1 + (l ? 8 : 7));
        end

        // break sweep: R8 R9
        cfg_len8 = 1'b1; cfg_parity = 2'd0; cfg_stop2 = 1'b0; cfg_msb_first = 1'b0;
        for (int sel = 0; sel < 8; sel++)
        for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            cfg_brk_sel = 3'(sel);
            cfg_invert = logic'(v);
            clear_cap();
            add_break(sel);
            write_brk();
            wait_idle("R8 busy clears");
            check_stream($sformatf("R8 break sel%0d inv%0d", sel, v), s);
            chk(done_cnt == 0, "R9 no pulse for break", done_cnt, 0);
        end

        // back-to-back characters with an ignored third write: R10
        @(negedge clk);
        cfg_invert = 1'b0;
        clear_cap();
        add_frame(8'hC3, 1'b1, 1, 1'b0, 1'b0);
        add_frame(8'h3E, 1'b1, 1, 1'b0, 1'b0);
        cfg_parity = 2'd1;
        write_chr(8'hC3);
        wait_start();
        write_chr(8'h3E);
        write_chr(8'hFF);
        wait_idle("R10 busy clears");
        check_stream("R10 held write follows with no gap, full write ignored", s);
        chk(done_cnt == 2, "R10 two done pulses", done_cnt, 2);

        // break followed by a held character: R8 R10
        @(negedge clk);
        cfg_parity = 2'd0;
        cfg_brk_sel = 3'd2;
        clear_cap();
        add_break(2);
        add_frame(8'h81, 1'b1, 0, 1'b0, 1'b0);
        write_brk();
        wait_start();
        write_chr(8'h81);
        wait_idle("R10 busy clears after break");
        check_stream("R10 R8 character after break idle bit", s);

        // simultaneous break and character: break wins R10
        @(negedge clk);
        clear_cap();
        add_break(2);
        @(negedge clk);
        wr_en = 1'b1; wr_break = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; wr_break = 1'b0;
        wait_idle("R10 busy clears after simultaneous write");
        check_stream("R10 break takes priority", s);
        chk(done_cnt == 0, "R10 no character sent", done_cnt, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule